// File: doc/BRIEF.md
# Still-Picture Step Controller

This block sequences the still-picture mode of a video decoder. The host controls it through a two-bit register. One bit turns still mode on. The other bit asks the block to show one more picture. When still mode turns on, the block flushes the compressed input buffer once and stops audio timestamp comparison. Audio stays unmuted. The block then lets the first intra-coded frame from the parser reach the display and drops every other frame until that one arrives. After showing it, the block pauses.

While paused, the host writes the step bit to ask for the next intra frame. The block releases exactly one intra frame and then clears the step bit itself. The host can poll the register to see when the request has been served. Clearing the mode bit returns the decoder to normal play, where every frame is displayed. Fast play and still mode must not be active together. If both are on, the block raises an error flag and refuses step requests until one of the two is cleared.

The controller is built as a four-state machine: `ST_NORMAL`, `ST_SEEK_FIRST`, `ST_PAUSE` and `ST_SEEK_NEXT`. Its transitions are:
- `ST_NORMAL` to `ST_SEEK_FIRST` when the mode bit is set. This is the entry, and the flush cycle.
- `ST_SEEK_FIRST` to `ST_PAUSE` when an intra frame is displayed.
- `ST_PAUSE` to `ST_SEEK_NEXT` when the step bit is set.
- `ST_SEEK_NEXT` to `ST_PAUSE` when an intra frame is displayed. This also clears the step bit.
- Any still state to `ST_NORMAL` when the mode bit is cleared.

Top module: `still_step_ctl`

## Requirements
- R1: After reset, `reg_rdata` is 0, and `flush`, `display_en`, `discard`, `paused`, `audio_sync_off` and `err_illegal` are all low.
- R2: While register bit 1 (mode) reads 0, every frame strobe is displayed (`display_en`=1, `discard`=0) whatever its type. Both outputs are combinational with the strobe.
- R3: A write that sets bit 1 while it was 0 gives `flush`=1 for exactly one cycle, namely the cycle after the write. During that cycle a frame strobe is discarded.
- R4: While the mode bit is 1, `audio_sync_off` is 1 and `audio_mute` is 0. In normal play, `audio_sync_off` is 0.
- R5: After entry, non-intra frames are discarded until the first intra frame, which is displayed.
- R6: After the first intra frame is displayed, `paused` is 1 and every frame is discarded while no step is pending.
- R7: Writing 1 to bit 0 (step) while paused releases the next intra frame for display. Non-intra frames before it are discarded.
- R8: The step bit clears itself the cycle after its intra frame is displayed, and `paused` returns to 1. If a new step write arrives in that same cycle, the write wins.
- R9: `err_illegal` goes high one cycle after `fast_mode` and the mode bit are both 1. It stays high until either of them is 0, and falls one cycle later.
- R10: While `err_illegal` is high, or while `fast_mode` is high with the mode bit set, a write of 1 to the step bit is ignored. The register still reads 0 in bit 0.
- R11: Writing 0 to the mode bit clears the step bit and returns the block to normal play. `paused` falls one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_wdata | input | 2 | Write data: bit 1 is the mode bit, bit 0 is the step bit |
| reg_rdata | output | 2 | Current register bits |
| fast_mode | input | 1 | Fast-play mode flag |
| frame_valid | input | 1 | Parser strobe: a frame header was detected |
| frame_is_intra | input | 1 | The detected frame is intra-coded |
| flush | output | 1 | One-cycle input-buffer flush |
| audio_sync_off | output | 1 | Audio timestamp comparison disabled |
| audio_mute | output | 1 | Audio mute, held low |
| display_en | output | 1 | Pass the current frame to display |
| discard | output | 1 | Drop the current frame |
| paused | output | 1 | Block is paused waiting for a step |
| err_illegal | output | 1 | Fast play and still mode both set |

## Verification
The assertions assume that `frame_valid` is a single-cycle strobe and that `frame_is_intra` is meaningful only with it. They also assume the host writes the register with `reg_wr` held for one cycle. The bench drives every input at the falling edge and pulses each strobe for one cycle only, so it never depends on values between strobes. The bench sweeps both frame types in every state. It also covers the case where fast mode is raised while the block is paused, so that the step-blocking path is reached legally.

// File: rtl/still_step_pkg.sv
package still_step_pkg;
    localparam int REG_W    = 2;
    localparam int MODE_BIT = 1;
    localparam int STEP_BIT = 0;

    typedef enum logic [1:0] {
        ST_NORMAL     = 2'd0,
        ST_SEEK_FIRST = 2'd1,
        ST_PAUSE      = 2'd2,
        ST_SEEK_NEXT  = 2'd3
    } still_state_t;
endpackage

// File: rtl/still_step_regs.sv
module still_step_regs
    import still_step_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             fast_mode,
    input  logic             step_done,
    output logic             mode_q,
    output logic             step_q,
    output logic             err_q,
    output logic [REG_W-1:0] rd_data
);
    logic mode_next;
    logic step_block;

    assign mode_next  = wr_en ? wr_data[MODE_BIT] : mode_q;
    assign step_block = err_q || fast_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            step_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            mode_q <= mode_next;
            err_q  <= fast_mode && mode_q;
            if (!mode_next)
                step_q <= 1'b0;
            else if (wr_en && wr_data[STEP_BIT] && !step_block)
                step_q <= 1'b1;
            else if (step_done)
                step_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data           = '0;
        rd_data[MODE_BIT] = mode_q;
        rd_data[STEP_BIT] = step_q;
    end

    // R8
    step_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && !(wr_en && wr_data[STEP_BIT])) |=> !step_q);

    // R9
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_mode && mode_q) |=> err_q);

    // R10
    err_blocks_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !step_q) |=> !step_q);

    // R11
    exit_clears_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[MODE_BIT]) |=> (!step_q && !mode_q));
endmodule

// File: rtl/still_step_fsm.sv
module still_step_fsm
    import still_step_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_q,
    input  logic step_q,
    input  logic frame_valid,
    input  logic frame_is_intra,
    output logic flush,
    output logic display_en,
    output logic discard,
    output logic paused,
    output logic sync_off,
    output logic step_done
);
    still_state_t state, state_next;
    logic intra_hit;

    assign intra_hit = frame_valid && frame_is_intra;

    always_comb begin
        state_next = state;
        unique case (state)
            ST_NORMAL:     if (mode_q) state_next = ST_SEEK_FIRST;
            ST_SEEK_FIRST: if (!mode_q) state_next = ST_NORMAL;
                           else if (intra_hit) state_next = ST_PAUSE;
            ST_PAUSE:      if (!mode_q) state_next = ST_NORMAL;
                           else if (step_q) state_next = ST_SEEK_NEXT;
            ST_SEEK_NEXT:  if (!mode_q) state_next = ST_NORMAL;
                           else if (intra_hit) state_next = ST_PAUSE;
            default:       state_next = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_NORMAL;
        else        state <= state_next;
    end

    always_comb begin
        flush      = 1'b0;
        display_en = 1'b0;
        paused     = 1'b0;
        step_done  = 1'b0;
        sync_off   = mode_q;
        unique case (state)
            ST_NORMAL: begin
                flush      = mode_q;
                display_en = frame_valid && !mode_q;
            end
            ST_SEEK_FIRST: begin
                display_en = frame_valid && (!mode_q || frame_is_intra);
            end
            ST_PAUSE: begin
                paused     = 1'b1;
                display_en = frame_valid && !mode_q;
            end
            ST_SEEK_NEXT: begin
                display_en = frame_valid && (!mode_q || frame_is_intra);
                step_done  = mode_q && intra_hit;
            end
            default: ;
        endcase
        discard = frame_valid && !display_en;
    end

    // R3
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    // R2
    normal_shows_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && !mode_q && frame_valid) |-> display_en);

    // R5
    still_intra_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && display_en) |-> frame_is_intra);

    // R6
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE && mode_q && !step_q) |=> (state == ST_PAUSE));

    // R7
    step_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE && mode_q && step_q) |=> (state == ST_SEEK_NEXT));
endmodule

// File: rtl/still_step_ctl.sv
module still_step_ctl
    import still_step_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             fast_mode,
    input  logic             frame_valid,
    input  logic             frame_is_intra,
    output logic             flush,
    output logic             audio_sync_off,
    output logic             audio_mute,
    output logic             display_en,
    output logic             discard,
    output logic             paused,
    output logic             err_illegal
);
    logic mode_q, step_q, step_done;

    still_step_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_data   (reg_wdata),
        .fast_mode (fast_mode),
        .step_done (step_done),
        .mode_q    (mode_q),
        .step_q    (step_q),
        .err_q     (err_illegal),
        .rd_data   (reg_rdata)
    );

    still_step_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_q         (mode_q),
        .step_q         (step_q),
        .frame_valid    (frame_valid),
        .frame_is_intra (frame_is_intra),
        .flush          (flush),
        .display_en     (display_en),
        .discard        (discard),
        .paused         (paused),
        .sync_off       (audio_sync_off),
        .step_done      (step_done)
    );

    assign audio_mute = 1'b0;

    // R4
    audio_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        audio_sync_off |-> !audio_mute);
endmodule

// File: tb/test_still_step_ctl.sv
module test_still_step_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_wdata = 2'b00;
    logic [1:0] reg_rdata;
    logic       fast_mode = 1'b0;
    logic       frame_valid = 1'b0;
    logic       frame_is_intra = 1'b0;
    logic       flush, audio_sync_off, audio_mute, display_en, discard, paused, err_illegal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    still_step_ctl i_still_step_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fast_mode(fast_mode), .frame_valid(frame_valid),
        .frame_is_intra(frame_is_intra), .flush(flush), .audio_sync_off(audio_sync_off),
        .audio_mute(audio_mute), .display_en(display_en), .discard(discard),
        .paused(paused), .err_illegal(err_illegal)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic host_write(input logic [1:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic frame(input logic intra);
        frame_valid = 1'b1;
        frame_is_intra = intra;
        #1;
    endtask

    task automatic no_frame();
        frame_valid = 1'b0;
        frame_is_intra = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 rdata", reg_rdata, 0);
        chk("R1 outs", {flush, display_en, discard, paused, audio_sync_off, err_illegal}, 0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < 4; i++) begin
            frame(i[0]);
            chk("R2 display", display_en, 1);
            chk("R2 discard", discard, 0);
            chk("R4 sync off normal", audio_sync_off, 0);
            tick();
        end
        no_frame();

        host_write(2'b10);
        frame(1'b1);
        chk("R3 flush", flush, 1);
        chk("R3 flush-cycle discard", discard, 1);
        chk("R4 sync_off", audio_sync_off, 1);
        chk("R4 mute", audio_mute, 0);
        chk("R3 rdata", reg_rdata, 2);
        tick();
        no_frame();
        #1;
        chk("R3 flush gone", flush, 0);

        for (int k = 0; k < 3; k++) begin
            frame(1'b0);
            chk("R5 drop non-intra", {display_en, discard}, 1);
            tick();
        end
        frame(1'b1);
        chk("R5 first intra", {display_en, discard}, 2);
        tick();
        no_frame();
        #1;
        chk("R6 paused", paused, 1);
        for (int k = 0; k < 4; k++) begin
            frame(k[0]);
            chk("R6 drop", {display_en, discard}, 1);
            chk("R6 still paused", paused, 1);
            tick();
        end
        no_frame();

        host_write(2'b11);
        chk("R7 step set", reg_rdata, 3);
        tick();
        chk("R7 left pause", paused, 0);
        frame(1'b0);
        chk("R7 drop non-intra", {display_en, discard}, 1);
        tick();
        frame(1'b1);
        chk("R7 release intra", {display_en, discard}, 2);
        tick();
        no_frame();
        #1;
        chk("R8 self clear", reg_rdata, 2);
        chk("R8 paused again", paused, 1);

        fast_mode = 1'b1;
        #1;
        chk("R9 err lags", err_illegal, 0);
        host_write(2'b11);
        chk("R10 step ignored same cycle", reg_rdata, 2);
        chk("R9 err set", err_illegal, 1);
        host_write(2'b11);
        chk("R10 step ignored", reg_rdata, 2);
        tick();
        frame(1'b1);
        chk("R10 still paused", paused, 1);
        chk("R10 intra dropped", discard, 1);
        tick();
        no_frame();
        fast_mode = 1'b0;
        #1;
        chk("R9 err held", err_illegal, 1);
        tick();
        chk("R9 err cleared", err_illegal, 0);

        host_write(2'b00);
        chk("R11 rdata", reg_rdata, 0);
        frame(1'b0);
        chk("R11 display on exit", display_en, 1);
        tick();
        no_frame();
        #1;
        chk("R11 unpaused", paused, 0);
        chk("R4 sync back on", audio_sync_off, 0);

        host_write(2'b11);
        tick();
        frame(1'b1);
        tick();
        no_frame();
        #1;
        chk("R6 paused re-entry", paused, 1);
        tick();
        chk("R7 pending step", paused, 0);
        host_write(2'b00);
        chk("R11 step cleared", reg_rdata, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule